// File: doc/BRIEF.md
# Fill-Word Elastic Retiming Buffer

This block moves a stream of 10-bit encoded characters from a recovered-clock domain into a local reference-clock domain. On the write side it collects characters into four-character words. A word starts on a character flagged by `w_align`, and `w_fill` marks the word as an idle fill word. The block places whole words into a small elasticity store. The read side emits one character per reference clock and marks the first character of every word, so every output edge is timed by the reference clock and none comes from the incoming clock.

The two clocks differ slightly in frequency, and the block compensates for this at word level. When the store fills up, the write side drops arriving fill words. When it runs low, the read side sends the previous fill word a second time. Data words and their order are never touched. Words that fall between two fill words can therefore grow or shrink in count, but a frame is always passed through intact. Write and read pointers cross between the clock domains in Gray code through two-flop synchronisers. Sticky flags record an overflow and an underflow.

Top module: `fw_elastic_retimer`

## Requirements
- R1: After reset the read side emits the idle word with characters 0x0FA, 0x2AA, 0x2AA, 0x2AA in slot order 0 to 3, with `r_word_start` high on slot 0, and both error flags are low.
- R2: `r_word_start` is high for exactly one `rclk` cycle out of every four, whatever the rate or jitter of `wclk`. The characters of a word leave in slot order 0, 1, 2, 3.
- R3: Every word that is accepted leaves the block in order and unaltered. Within a frame (a run of words written with `w_fill` low), no fill word ever appears between two of its data words.
- R4: A completed fill word is discarded when the write-side occupancy is above HI_MARK (default 2 words). Data words are never discarded for rate matching.
- R5: At the last character of an output word, if that word is a fill word and the read-side occupancy is below LO_MARK (default 2 words), the same word is sent again and the store is not read.
- R6: Occupancy never exceeds DEPTH_WORDS (default 4 words, 16 characters). This keeps the delay from the last character written to the first character emitted within 30 `rclk` cycles.
- R7: A completed word that is not dropped and finds the store full is lost, and `err_overflow` is set. The flag stays high until reset.
- R8: At a word boundary, if the store is empty and the word just sent was a data word, the idle word of R1 is sent and `err_underflow` is set. The flag stays high until reset.
- R9: A character with `w_align` high opens a word in slot 0, and `w_fill` is sampled with it. A word cut short by a new `w_align` is discarded, and characters that arrive while no word is open are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wclk | input | 1 | Recovered (write) clock |
| rclk | input | 1 | Local reference (read) clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| w_char | input | 10 | Incoming encoded character |
| w_align | input | 1 | High on the first character of a word |
| w_fill | input | 1 | With `w_align`: the word is a fill word |
| r_char | output | 10 | Retimed character |
| r_word_start | output | 1 | High on slot 0 of each output word |
| err_overflow | output | 1 | Sticky: a word was lost to a full store |
| err_underflow | output | 1 | Sticky: the store ran empty after a data word |

## Verification
Some properties are checked by the assertions on every cycle: each side's view of the occupancy stays within the store depth; each synchronised pointer moves by at most one Gray bit per clock; a dropped fill word leaves the write pointer unchanged; an inserted word keeps both the output register and the read pointer still; and both error flags are sticky. Other behaviour can only be shown by the bench's scenarios, because it emerges over many words at the ports. These are the intact, gap-free order of data across frames, the net gain of fill words when the writer is slow and the net loss when it is fast, the discarding of a truncated word, the latency bound, and the two error conditions.

// File: rtl/efb_pkg.sv
`timescale 1ns/1ps
package efb_pkg;
  localparam int CHAR_W     = 10;
  localparam int WORD_CHARS = 4;

  typedef logic [CHAR_W-1:0] char_t;
  typedef logic [WORD_CHARS-1:0][CHAR_W-1:0] word_t;

  typedef struct packed {
    logic  fill;
    word_t data;
  } entry_t;

  // slot 0 is the comma-led character
  localparam word_t IDLE_DEFAULT = {10'h2AA, 10'h2AA, 10'h2AA, 10'h0FA};
endpackage

// File: rtl/efb_ptr_sync.sv
`timescale 1ns/1ps
module efb_ptr_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] pipe;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe[s] <= '0;
        else        pipe[s] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe[s] <= '0;
        else        pipe[s] <= pipe[s-1];
      end
    end
  end

  assign q = pipe[STAGES-1];

  // Gray pointer seen in the far domain never jumps by more than one bit
  assert_sync_single_bit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(q ^ $past(q)) <= 1);
endmodule

// File: rtl/efb_wr_side.sv
`timescale 1ns/1ps
module efb_wr_side import efb_pkg::*; #(
  parameter int DEPTH   = 4,
  parameter int HI_MARK = 2,
  localparam int PW     = $clog2(DEPTH) + 1,
  localparam int AW     = PW - 1
) (
  input  logic          wclk,
  input  logic          rst_n,
  input  char_t         w_char,
  input  logic          w_align,
  input  logic          w_fill,
  input  logic [PW-1:0] rgray_s,
  output logic          we,
  output logic [AW-1:0] waddr,
  output entry_t        wdata,
  output logic [PW-1:0] wgray,
  output logic          err_ovf
);
  localparam int IW = $clog2(WORD_CHARS);
  localparam logic [IW-1:0] LAST   = IW'(WORD_CHARS - 1);
  localparam logic [PW-1:0] HI_L   = PW'(HI_MARK);
  localparam logic [PW-1:0] FULL_L = PW'(DEPTH);

  function automatic logic [PW-1:0] g2b(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  function automatic logic [PW-1:0] b2g(input logic [PW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  logic [IW-1:0] slot;
  logic          busy, fill_q;
  word_t         part;
  logic [PW-1:0] wbin, occ;
  logic          word_done, fill_drop, store_full, push, ovf_evt;

  // internal events, named for the assertions
  always_comb begin
    occ        = wbin - g2b(rgray_s);
    word_done  = busy && !w_align && (slot == LAST);
    store_full = (occ >= FULL_L);
    fill_drop  = word_done && fill_q && (occ > HI_L);
    push       = word_done && !fill_drop && !store_full;
    ovf_evt    = word_done && !fill_drop && store_full;
  end

  always_comb begin
    wdata.fill       = fill_q;
    wdata.data       = part;
    wdata.data[LAST] = w_char;
  end

  // word assembly: align opens slot 0, a fresh align abandons a partial word
  always_ff @(posedge wclk or negedge rst_n) begin
    if (!rst_n) begin
      slot   <= '0;
      busy   <= 1'b0;
      fill_q <= 1'b0;
      part   <= '0;
    end else if (w_align) begin
      part[0] <= w_char;
      slot    <= IW'(1);
      busy    <= 1'b1;
      fill_q  <= w_fill;
    end else if (busy) begin
      part[slot] <= w_char;
      if (slot == LAST) busy <= 1'b0;
      else              slot <= slot + IW'(1);
    end
  end

  always_ff @(posedge wclk or negedge rst_n) begin
    if (!rst_n) begin
      wbin    <= '0;
      wgray   <= '0;
      err_ovf <= 1'b0;
    end else begin
      if (push) begin
        wbin  <= wbin + PW'(1);
        wgray <= b2g(wbin + PW'(1));
      end
      if (ovf_evt) err_ovf <= 1'b1;
    end
  end

  assign we    = push;
  assign waddr = wbin[AW-1:0];

  assert_occupancy_bound_wr_R6: assert property (@(posedge wclk) disable iff (!rst_n)
    occ <= FULL_L);
  assert_drop_keeps_ptr_R4: assert property (@(posedge wclk) disable iff (!rst_n)
    fill_drop |=> $stable(wbin));
  assert_push_gray_step_R3: assert property (@(posedge wclk) disable iff (!rst_n)
    push |=> ($countones(wgray ^ $past(wgray)) == 1));
  assert_overflow_sticky_R7: assert property (@(posedge wclk) disable iff (!rst_n)
    err_ovf |=> err_ovf);
endmodule

// File: rtl/efb_rd_side.sv
`timescale 1ns/1ps
module efb_rd_side import efb_pkg::*; #(
  parameter int    DEPTH     = 4,
  parameter int    LO_MARK   = 2,
  parameter word_t IDLE_WORD = IDLE_DEFAULT,
  localparam int   PW        = $clog2(DEPTH) + 1,
  localparam int   AW        = PW - 1
) (
  input  logic          rclk,
  input  logic          rst_n,
  input  logic [PW-1:0] wgray_s,
  input  entry_t        rd_entry,
  output logic [AW-1:0] raddr,
  output logic [PW-1:0] rgray,
  output char_t         r_char,
  output logic          r_word_start,
  output logic          err_unf
);
  localparam int IW = $clog2(WORD_CHARS);
  localparam logic [IW-1:0] LAST   = IW'(WORD_CHARS - 1);
  localparam logic [PW-1:0] LO_L   = PW'(LO_MARK);
  localparam logic [PW-1:0] FULL_L = PW'(DEPTH);

  function automatic logic [PW-1:0] g2b(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  function automatic logic [PW-1:0] b2g(input logic [PW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  logic [IW-1:0] ridx;
  entry_t        cur;
  logic [PW-1:0] rbin, occ;
  logic          at_end, insert_evt, starve, pop;

  always_comb begin
    occ        = g2b(wgray_s) - rbin;
    at_end     = (ridx == LAST);
    insert_evt = at_end && cur.fill && (occ < LO_L);
    starve     = at_end && !cur.fill && (occ == '0);
    pop        = at_end && !insert_evt && !starve;
  end

  always_ff @(posedge rclk or negedge rst_n) begin
    if (!rst_n) begin
      ridx    <= '0;
      cur     <= {1'b1, IDLE_WORD};
      rbin    <= '0;
      rgray   <= '0;
      err_unf <= 1'b0;
    end else begin
      ridx <= at_end ? '0 : ridx + IW'(1);
      if (pop) begin
        cur   <= rd_entry;
        rbin  <= rbin + PW'(1);
        rgray <= b2g(rbin + PW'(1));
      end
      if (starve) begin
        cur     <= {1'b1, IDLE_WORD};
        err_unf <= 1'b1;
      end
    end
  end

  assign raddr        = rbin[AW-1:0];
  assign r_char       = cur.data[ridx];
  assign r_word_start = (ridx == '0);

  assert_occupancy_bound_rd_R6: assert property (@(posedge rclk) disable iff (!rst_n)
    occ <= FULL_L);
  assert_insert_repeat_R5: assert property (@(posedge rclk) disable iff (!rst_n)
    insert_evt |=> ($stable(cur) && $stable(rbin)));
  assert_word_start_single_R2: assert property (@(posedge rclk) disable iff (!rst_n)
    r_word_start |=> !r_word_start);
  assert_underflow_sticky_R8: assert property (@(posedge rclk) disable iff (!rst_n)
    err_unf |=> err_unf);
endmodule

// File: rtl/fw_elastic_retimer.sv
`timescale 1ns/1ps
module fw_elastic_retimer import efb_pkg::*; #(
  parameter int    DEPTH_WORDS = 4,
  parameter int    HI_MARK     = 2,
  parameter int    LO_MARK     = 2,
  parameter int    SYNC_STAGES = 2,
  parameter word_t IDLE_WORD   = IDLE_DEFAULT
) (
  input  logic              wclk,
  input  logic              rclk,
  input  logic              rst_n,
  input  logic [CHAR_W-1:0] w_char,
  input  logic              w_align,
  input  logic              w_fill,
  output logic [CHAR_W-1:0] r_char,
  output logic              r_word_start,
  output logic              err_overflow,
  output logic              err_underflow
);
  localparam int PW = $clog2(DEPTH_WORDS) + 1;
  localparam int AW = PW - 1;

  logic          we;
  logic [AW-1:0] waddr, raddr;
  entry_t        wdata, rd_entry;
  logic [PW-1:0] wgray, rgray, wgray_s, rgray_s;
  entry_t        store [DEPTH_WORDS];

  always_ff @(posedge wclk) begin
    if (we) store[waddr] <= wdata;
  end
  assign rd_entry = store[raddr];

  efb_wr_side #(.DEPTH(DEPTH_WORDS), .HI_MARK(HI_MARK)) u_wr (
    .wclk(wclk), .rst_n(rst_n), .w_char(w_char), .w_align(w_align),
    .w_fill(w_fill), .rgray_s(rgray_s), .we(we), .waddr(waddr),
    .wdata(wdata), .wgray(wgray), .err_ovf(err_overflow)
  );

  efb_rd_side #(.DEPTH(DEPTH_WORDS), .LO_MARK(LO_MARK), .IDLE_WORD(IDLE_WORD)) u_rd (
    .rclk(rclk), .rst_n(rst_n), .wgray_s(wgray_s), .rd_entry(rd_entry),
    .raddr(raddr), .rgray(rgray), .r_char(r_char),
    .r_word_start(r_word_start), .err_unf(err_underflow)
  );

  efb_ptr_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_sync_r2w (
    .clk(wclk), .rst_n(rst_n), .d(rgray), .q(rgray_s)
  );

  efb_ptr_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_sync_w2r (
    .clk(rclk), .rst_n(rst_n), .d(wgray), .q(wgray_s)
  );
endmodule

// File: tb/test_fw_elastic_retimer.sv
`timescale 1ns/1ps
module test_fw_elastic_retimer;
  import efb_pkg::*;

  localparam int    FRAME = 6;
  localparam word_t IDLE  = IDLE_DEFAULT;

  logic       wclk = 1'b0, rclk = 1'b0, rst_n = 1'b0;
  logic [9:0] w_char = '0;
  logic       w_align = 1'b0, w_fill = 1'b0;
  logic [9:0] r_char;
  logic       r_word_start, err_overflow, err_underflow;

  fw_elastic_retimer i_fw_elastic_retimer (
    .wclk(wclk), .rclk(rclk), .rst_n(rst_n), .w_char(w_char),
    .w_align(w_align), .w_fill(w_fill), .r_char(r_char),
    .r_word_start(r_word_start), .err_overflow(err_overflow),
    .err_underflow(err_underflow)
  );

  realtime w_half = 2.0;
  realtime w_jit  = 0.0;
  bit      w_run  = 1'b1;

  initial forever #2 rclk = ~rclk;
  initial forever begin
    if (w_run) begin
      #(w_half + w_jit) wclk = ~wclk;
      #(w_half - w_jit) wclk = ~wclk;
    end else #1;
  end

  int main_checks = 0, main_errs = 0, mon_checks = 0, mon_errs = 0;

  function automatic word_t mk_data(int seq);
    word_t w;
    for (int k = 0; k < 4; k++) w[k] = {2'(k), seq[7:0]};
    return w;
  endfunction

  // ---------------- writer ----------------
  int      wr_seq = 0;
  realtime wr_time [256];

  task automatic send_word(word_t w, bit fill, bit stamp, int seq);
    for (int k = 0; k < 4; k++) begin
      @(negedge wclk);
      w_char  = w[k];
      w_align = (k == 0);
      w_fill  = fill;
    end
    if (stamp) wr_time[seq % 256] = $realtime;
  endtask

  task automatic send_frames(int n, int gap);
    for (int f = 0; f < n; f++) begin
      for (int d = 0; d < FRAME; d++) begin
        send_word(mk_data(wr_seq), 1'b0, 1'b1, wr_seq);
        wr_seq++;
      end
      for (int g = 0; g < gap; g++) send_word(IDLE, 1'b1, 1'b0, 0);
    end
  endtask

  // ---------------- monitor ----------------
  int      mon_gen = 0;
  bit      mon_en = 1'b0, seq_check = 1'b0, frame_check = 1'b0, lat_check = 1'b0;
  string   tag = "R3";
  int      gen_seen = 0, cyc_since = 0, cidx = 0, exp_seq = 0;
  int      pend_fill = 0, fills_out = 0, data_out = 0;
  bit      seen_start = 1'b0, any_data = 1'b0;
  word_t   got;
  realtime start_t;

  task automatic judge();
    realtime lat;
    if (got == mk_data(exp_seq)) begin
      if (seq_check) mon_checks++;
      if (lat_check) begin
        mon_checks++;
        lat = start_t - wr_time[exp_seq % 256];
        if (lat > 120.0) begin
          mon_errs++;
          $display("FAIL R6: latency %0t ns for word %0d, expected <= 120", lat, exp_seq);
        end
      end
      fills_out += pend_fill;
      pend_fill = 0;
      exp_seq++;
      data_out++;
      any_data = 1'b1;
    end else if (got == IDLE) begin
      if (any_data) pend_fill++;
      if (frame_check && any_data && (exp_seq % FRAME != 0)) begin
        mon_checks++;
        mon_errs++;
        $display("FAIL R3: fill word inside frame, actual idle, expected data %h", mk_data(exp_seq));
      end
    end else if (seq_check) begin
      mon_checks++;
      mon_errs++;
      $display("FAIL %s: word actual %h expected %h", tag, got, mk_data(exp_seq));
    end
  endtask

  always @(negedge rclk) begin
    if (gen_seen != mon_gen) begin
      gen_seen = mon_gen; seen_start = 1'b0; cidx = 0; exp_seq = 0;
      any_data = 1'b0; pend_fill = 0; fills_out = 0; data_out = 0;
    end else if (mon_en) begin
      if (r_word_start) begin
        if (seen_start) begin
          mon_checks++;
          if (cyc_since != 4) begin
            mon_errs++;
            $display("FAIL R2: word start spacing actual %0d expected 4", cyc_since);
          end
        end
        seen_start = 1'b1; cyc_since = 0; cidx = 0; start_t = $realtime;
      end
      cyc_since++;
      if (seen_start && cidx < 4) begin
        got[cidx] = r_char;
        if (cidx == 3) judge();
        cidx++;
      end
    end
  end

  // ---------------- main sequence ----------------
  task automatic check(bit ok, string req, string what, int act, int exp);
    main_checks++;
    if (!ok) begin
      main_errs++;
      $display("FAIL %s: %s actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    mon_en = 1'b0;
    w_run  = 1'b1;
    rst_n  = 1'b0;
    w_align = 1'b0; w_fill = 1'b0; w_char = '0;
    wr_seq = 0;
    #40;
    mon_gen++;
    @(negedge rclk);
    #0.5 rst_n = 1'b1;
  endtask

  task automatic drain();
    for (int g = 0; g < 6; g++) send_word(IDLE, 1'b1, 1'b0, 0);
    #300;
  endtask

  initial begin
    // S1: equal rate, heavy jitter, reset state, alignment
    w_half = 2.0; w_jit = 0.3;
    do_reset();
    #0.1;
    check(r_word_start == 1'b1, "R1", "word start on slot 0", r_word_start, 1);
    check(r_char == 10'h0FA, "R1", "idle slot 0", r_char, 10'h0FA);
    check(!err_overflow && !err_underflow, "R1", "error flags", {err_overflow, err_underflow}, 0);
    for (int k = 1; k < 4; k++) begin
      @(negedge rclk);
      check(r_char == 10'h2AA, "R1", "idle later slot", r_char, 10'h2AA);
    end
    seq_check = 1'b1; frame_check = 1'b1; lat_check = 1'b1; tag = "R3";
    mon_en = 1'b1;
    send_frames(20, 2);
    tag = "R9";
    @(negedge wclk); w_char = 10'h3AA; w_align = 1'b1; w_fill = 1'b0;
    @(negedge wclk); w_char = 10'h3AB; w_align = 1'b0;
    send_frames(2, 2);
    @(negedge wclk); w_char = 10'h3AC; w_align = 1'b1;
    @(negedge wclk); w_char = 10'h3AD; w_align = 1'b0;
    @(negedge wclk); w_char = 10'h3AE;
    send_frames(3, 2);
    drain();
    check(data_out == wr_seq, "R9", "data words out after truncated words", data_out, wr_seq);
    check(!err_overflow, "R7", "no overflow at equal rate", err_overflow, 0);
    check(!err_underflow, "R8", "no underflow at equal rate", err_underflow, 0);

    // S2: slow writer, fills must be added
    w_half = 2.06; w_jit = 0.1; tag = "R3";
    do_reset(); mon_en = 1'b1;
    send_frames(150, 2);
    drain();
    check(data_out == wr_seq, "R3", "data words out, slow writer", data_out, wr_seq);
    check(fills_out >= 149 * 2 + 10, "R5", "fills between frames, slow writer (min)", fills_out, 149 * 2 + 10);
    check(!err_underflow, "R8", "no underflow, slow writer", err_underflow, 0);

    // S3: fast writer, fills must be dropped
    w_half = 1.94; w_jit = 0.1;
    do_reset(); mon_en = 1'b1;
    send_frames(150, 2);
    drain();
    check(data_out == wr_seq, "R3", "data words out, fast writer", data_out, wr_seq);
    check(fills_out + 10 <= 149 * 2, "R4", "fills between frames, fast writer (max)", fills_out, 149 * 2 - 10);
    check(!err_overflow, "R7", "no overflow, fast writer", err_overflow, 0);

    // S4: fast writer with no fills: overflow
    w_half = 1.90; w_jit = 0.0;
    seq_check = 1'b0; frame_check = 1'b0; lat_check = 1'b0;
    do_reset(); mon_en = 1'b1;
    send_frames(40, 0);
    check(err_overflow == 1'b1, "R7", "overflow flag", err_overflow, 1);
    check(err_underflow == 1'b0, "R8", "no underflow during overflow", err_underflow, 0);
    drain();
    check(err_overflow == 1'b1, "R7", "overflow flag sticky", err_overflow, 1);

    // S5: write clock lost mid-frame: underflow
    w_half = 2.0; w_jit = 0.0;
    seq_check = 1'b1; tag = "R8";
    do_reset(); mon_en = 1'b1;
    send_frames(3, 2);
    for (int d = 0; d < 3; d++) begin
      send_word(mk_data(wr_seq), 1'b0, 1'b1, wr_seq);
      wr_seq++;
    end
    @(posedge wclk);
    #0.5 w_run = 1'b0;
    #300;
    check(err_underflow == 1'b1, "R8", "underflow flag", err_underflow, 1);
    check(err_overflow == 1'b0, "R7", "no overflow on clock loss", err_overflow, 0);
    check(data_out == wr_seq, "R8", "data out before underflow", data_out, wr_seq);
    mon_en = 1'b0;
    while (1) begin
      @(negedge rclk);
      if (r_word_start) break;
    end
    check(r_char == 10'h0FA, "R8", "idle slot 0 after underflow", r_char, 10'h0FA);
    for (int k = 1; k < 4; k++) begin
      @(negedge rclk);
      check(r_char == 10'h2AA, "R8", "idle later slot after underflow", r_char, 10'h2AA);
    end
    #200;
    check(err_underflow == 1'b1, "R8", "underflow flag sticky", err_underflow, 1);
    w_run = 1'b1;

    $display("Simulation finished: %0d checks, %0d errors",
             main_checks + mon_checks, main_errs + mon_errs);
    $finish;
  end

  initial begin
    #700000;
    $display("FAIL watchdog: run incomplete, actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors",
             main_checks + mon_checks + 1, main_errs + mon_errs + 1);
    $finish;
  end
endmodule